// File: doc/BRIEF.md
# Phase-Continuous Two-Tone Digital Synthesizer

This block turns a serial stream of data bits into a sampled binary-FSK sine wave. A 32-bit phase register advances by a tuning word on every sample tick. The top bits of the phase drive a sine table that stores one quarter of a period and recovers the other three quarters by symmetry. Each output is a 12-bit two's-complement sample that can feed a DAC or a digital up-converter.

Two tuning words are presented on input ports: the mark word for data 1 (the higher tone) and the space word for data 0 (the lower tone). A bit strobe marks each bit boundary. At the strobe the block latches the data bit and copies the matching tuning word into the active step register. That tone then holds until the next strobe, so each tone lasts exactly one bit period. The phase register is never cleared at a bit boundary, so the waveform stays continuous when the tone changes.

Top module: `fsk_dds_mod`

## Requirements
- R1: Reset drives `wave_out` to 0 and `wave_vld` to 0, and clears the phase and the active step to 0. Until the first `bit_stb` the phase stays at 0, so every sample equals the address-0 value (6).
- R2: On a cycle with `bit_stb` high, `bit_val`=1 loads `mark_word` as the active step and `bit_val`=0 loads `space_word`.
- R3: `mark_word`, `space_word` and `bit_val` are ignored in any cycle where `bit_stb` is low. Changing them between strobes does not change the samples.
- R4: On each cycle with `tick` high, the phase advances by the active step modulo 2^32. On a cycle with `tick` low, the phase holds.
- R5: A bit strobe never resets or otherwise disturbs the phase. Only the step used by later ticks changes.
- R6: `wave_vld` is high exactly 2 clock cycles after each cycle in which `tick` is high, and low otherwise.
- R7: The sample for a tick comes from the phase before that tick's advance. Its table address `a` is the top 10 phase bits (bit 31 down to bit 22). The sample is within 5 LSB of round(2047·sin(2π(a+0.5)/1024)), in 12-bit two's complement.
- R8: Addresses with bit 9 set (the second half of the period) give samples ≤ 0. Addresses with bit 9 clear give samples ≥ 0.
- R9: If `bit_stb` and `tick` are high in the same cycle, that tick still uses the previous step. The new step applies from the next tick on.
- R10: `wave_out` keeps its last value in every cycle where `wave_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable; one output sample per high cycle |
| bit_stb | input | 1 | Bit-boundary strobe |
| bit_val | input | 1 | Data bit captured at the strobe |
| mark_word | input | 32 | Tuning word for data 1 (higher tone) |
| space_word | input | 32 | Tuning word for data 0 (lower tone) |
| wave_out | output | 12 | Signed sine sample |
| wave_vld | output | 1 | Sample valid, two cycles after `tick` |

## Verification
The bench targets a strobe that lands in the same cycle as a tick. A design that applies the new word at once would shift every later sample by one step of phase difference. It switches tones on every bit and checks that the phase carries across each switch. A design that clears the phase at a boundary would restart the sine at address 0, and the samples would show it. The bench changes the word ports between strobes; a design that reads them live would follow the new tone early. It also drives a tick pattern with gaps and checks the latency, sends a large word through the 2^32 wrap, and sweeps every quadrant, where a mirror or sign fold error would produce a jump of hundreds of LSB.

// File: rtl/fskdds_pkg.sv
package fskdds_pkg;

  // Magnitude of a quarter-wave entry. The sample sits half an address
  // step into its slot, so the sine is evaluated at pi*x/h with x = 2*idx+1
  // and h = 2^addr_w. A rational sine approximation keeps this an integer
  // constant function: 16p/(5h^2-4p) with p = x*(h-x).
  function automatic int qsin_val(input int idx, input int addr_w, input int amp);
    longint h;
    longint x;
    longint p;
    longint den;
    longint num;
    h   = longint'(1) << addr_w;
    x   = 2 * longint'(idx) + 1;
    p   = x * (h - x);
    den = 5 * h * h - 4 * p;
    num = 32 * longint'(amp) * p + den;
    return int'(num / (2 * den));
  endfunction

  // Phase update, kept here so the modulo rule reads in one place.
  function automatic logic [31:0] phase_next(input logic [31:0] ph, input logic [31:0] step);
    return ph + step;
  endfunction

endpackage

// File: rtl/fsk_word_latch.sv
module fsk_word_latch #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic [PHASE_W-1:0] mark_word,
  input  logic [PHASE_W-1:0] space_word,
  output logic [PHASE_W-1:0] step_word
);

  logic [PHASE_W-1:0] step_q;
  logic [PHASE_W-1:0] chosen;

  assign chosen = bit_val ? mark_word : space_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (bit_stb) step_q <= chosen;
  end

  assign step_word = step_q;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(step_word)); // R3
  AST_MARK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && bit_val) |=> step_word == $past(mark_word)); // R2
  AST_SPACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !bit_val) |=> step_word == $past(space_word)); // R2

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] step_word,
  output logic [ADDR_W-1:0]  lut_addr,
  output logic               lut_go
);

  logic [PHASE_W-1:0] phase_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      addr_q  <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= tick;
      if (tick) begin
        addr_q  <= phase_q[PHASE_W-1 -: ADDR_W];
        phase_q <= fskdds_pkg::phase_next(phase_q, step_word);
      end
    end
  end

  assign lut_addr = addr_q;
  assign lut_go   = go_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q)); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_q == $past(phase_q) + $past(step_word)); // R5
  AST_ADDR_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lut_go); // R6

endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lut_addr,
  input  logic              lut_go,
  output logic [SAMP_W-1:0] wave_out,
  output logic              wave_vld
);

  localparam int QTR_W     = ADDR_W - 2;
  localparam int QTR_DEPTH = 1 << QTR_W;
  localparam int MAG_W     = SAMP_W - 1;
  localparam int AMP       = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [QTR_DEPTH];

  for (genvar g = 0; g < QTR_DEPTH; g++) begin : g_rom
    localparam logic [MAG_W-1:0] ENTRY = MAG_W'(fskdds_pkg::qsin_val(g, ADDR_W, AMP));
    assign tbl[g] = ENTRY;
  end

  logic               neg_half;
  logic               mirror;
  logic [QTR_W-1:0]   idx;
  logic [MAG_W-1:0]   mag;
  logic signed [SAMP_W-1:0] folded;
  logic [SAMP_W-1:0]  wave_q;
  logic               vld_q;

  assign neg_half = lut_addr[ADDR_W-1];
  assign mirror   = lut_addr[ADDR_W-2];
  assign idx      = mirror ? ~lut_addr[QTR_W-1:0] : lut_addr[QTR_W-1:0];
  assign mag      = tbl[idx];

  always_comb begin
    folded = $signed({1'b0, mag});
    if (neg_half) folded = -$signed({1'b0, mag});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= lut_go;
      if (lut_go) wave_q <= folded;
    end
  end

  assign wave_out = wave_q;
  assign wave_vld = vld_q;

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    lut_go |=> wave_vld); // R6
  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_go && neg_half) |=> $signed(wave_out) <= 0); // R8
  AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_go && !neg_half) |=> $signed(wave_out) >= 0); // R8
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lut_go |=> $stable(wave_out)); // R10

endmodule

// File: rtl/fsk_dds_mod.sv
module fsk_dds_mod #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic [PHASE_W-1:0] mark_word,
  input  logic [PHASE_W-1:0] space_word,
  output logic [SAMP_W-1:0]  wave_out,
  output logic               wave_vld
);

  logic [PHASE_W-1:0] step_word;
  logic [ADDR_W-1:0]  lut_addr;
  logic               lut_go;

  fsk_word_latch #(.PHASE_W(PHASE_W)) u_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .mark_word  (mark_word),
    .space_word (space_word),
    .step_word  (step_word)
  );

  fsk_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .step_word (step_word),
    .lut_addr  (lut_addr),
    .lut_go    (lut_go)
  );

  fsk_sine_lut #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_lut (
    .clk      (clk),
    .rst_n    (rst_n),
    .lut_addr (lut_addr),
    .lut_go   (lut_go),
    .wave_out (wave_out),
    .wave_vld (wave_vld)
  );

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !lut_go) |=> !wave_vld); // R6
  AST_STEP_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && tick) |=> lut_go); // R9

endmodule

// File: tb/sim_fsk_dds_mod.sv
module sim_fsk_dds_mod;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bit_stb = 1'b0;
  logic        bit_val = 1'b0;
  logic [31:0] mark_word = '0;
  logic [31:0] space_word = '0;
  logic [11:0] wave_out;
  logic        wave_vld;

  fsk_dds_mod u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_stb(bit_stb), .bit_val(bit_val),
    .mark_word(mark_word), .space_word(space_word),
    .wave_out(wave_out), .wave_vld(wave_vld)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference state, built from the requirements.
  bit [31:0] m_ph   = '0;
  bit [31:0] m_step = '0;
  bit        m_en1  = 1'b0;
  bit        m_en2  = 1'b0;
  bit [31:0] m_p1   = '0;
  bit [31:0] m_p2   = '0;
  int        m_last = 0;
  string     tag    = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act_v, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  function automatic int ideal(input bit [9:0] a);
    real r;
    r = 2047.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 1024.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  // One clock: drive, let the edge pass, advance the model, check outputs.
  task automatic step(input bit en, input bit stb, input bit b, input bit [31:0] hi, input bit [31:0] lo);
    int got;
    int want;
    int diff;
    @(negedge clk);
    tick = en; bit_stb = stb; bit_val = b; mark_word = hi; space_word = lo;
    @(posedge clk);
    m_en2 = m_en1; m_p2 = m_p1;
    m_en1 = en;    m_p1 = m_ph;
    if (en)  m_ph = m_ph + m_step;
    if (stb) m_step = b ? hi : lo;
    #2;
    got = $signed(wave_out);
    chk(wave_vld == m_en2, {tag, "/R6"}, "valid", int'(wave_vld), int'(m_en2));
    if (m_en2) begin
      want = ideal(m_p2[31:22]);
      diff = got - want;
      chk(diff <= 5 && diff >= -5, {tag, "/R7"}, "sample", got, want);
      m_last = got;
    end else begin
      chk(got == m_last, {tag, "/R10"}, "held sample", got, m_last);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, mark_word, space_word);
  endtask

  task automatic test_reset();
    tag = "R1";
    #1;
    chk(wave_vld == 1'b0, "R1", "valid in reset", int'(wave_vld), 0);
    chk($signed(wave_out) == 0, "R1", "sample in reset", $signed(wave_out), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h0765_4321);
    chk(m_last == 6, "R1", "sample before first strobe", m_last, 6);
    flush();
  endtask

  task automatic test_mark_space();
    tag = "R2";
    step(1'b0, 1'b1, 1'b1, 32'h0200_0000, 32'h0080_0000);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 32'h0200_0000, 32'h0080_0000);
    step(1'b0, 1'b1, 1'b0, 32'h0200_0000, 32'h0080_0000);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 32'h0200_0000, 32'h0080_0000);
    flush();
  endtask

  task automatic test_word_hold();
    tag = "R3";
    step(1'b0, 1'b1, 1'b1, 32'h0310_0000, 32'h0011_0000);
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b0, i[0], 32'h0F00_0000 + 32'(i) * 32'h0100_0000, 32'h7000_0000);
    flush();
  endtask

  task automatic test_continuity();
    tag = "R5";
    for (int b = 0; b < 8; b++) begin
      step(1'b1, 1'b0, 1'b0, 32'h0400_0000, 32'h0130_0000);
      step(1'b0, 1'b1, b[0], 32'h0400_0000, 32'h0130_0000);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 32'h0400_0000, 32'h0130_0000);
    end
    flush();
  endtask

  task automatic test_same_cycle();
    tag = "R9";
    step(1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0100_0000);
    step(1'b1, 1'b1, 1'b1, 32'h2000_0000, 32'h0100_0000);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    flush();
  endtask

  task automatic test_gaps();
    tag = "R4";
    step(1'b0, 1'b1, 1'b1, 32'h0520_0000, 32'h0);
    for (int i = 0; i < 30; i++) step(i % 3 != 1, 1'b0, 1'b0, 32'h0, 32'h0);
    flush();
  endtask

  task automatic test_wrap_sweep();
    tag = "R8";
    step(1'b0, 1'b1, 1'b0, 32'h0, 32'h9350_0000);
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    step(1'b0, 1'b1, 1'b1, 32'h003F_F000, 32'h0);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    flush();
  endtask

  initial begin
    test_reset();
    test_mark_space();
    test_word_hold();
    test_continuity();
    test_same_cycle();
    test_gaps();
    test_wrap_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule